// File: doc/BRIEF.md
# Precise Exception Tracker for a Five-Stage Pipeline

This block keeps exceptions precise in an in-order pipeline with fetch, decode, execute, memory and writeback stages. Each stage register holds the PC, a valid bit and a three-bit cause code for its instruction. A fault flagged in a stage is attached to the instruction in that stage and travels with it. Nothing happens until that instruction reaches writeback. At that point the tracker saves the instruction's PC and cause, sends fetch to a fixed vector address, and empties every younger stage.

An external interrupt does not stop the pipeline at once. While the request is high and no interrupt no-op is in flight, the slot that would have carried the fetched instruction becomes a no-op tagged with the interrupt cause. That no-op then waits its turn at writeback like any other fault. The surrounding datapath uses `commit_o` to gate register-file writes and `dmem_we_o` to gate stores. A tagged instruction never gets either.

Top module: `exc_tracker`

## Requirements
- R1: After a synchronous active-low reset, the fetch PC equals RESET_PC, every stage is empty, and the saved exception PC and cause both read zero.
- R2: While no exception is taken, the fetch PC advances by 4 every cycle. An untagged instruction reaches writeback four cycles after it was fetched, and `wb_pc_o` then shows its PC.
- R3: Cause codes are: 0 none, 1 interrupt, 2 fetch translation fault, 3 illegal instruction (decode), 4 arithmetic overflow (execute), 5 data translation fault (memory). Each fault input tags whichever valid instruction sits in its stage.
- R4: An instruction flagged in more than one stage keeps the code of the earliest stage.
- R5: When a tagged instruction is in writeback, `take_o` is high. On the next edge the saved exception PC takes its PC, the saved cause takes its code, and the fetch PC becomes VEC_ADDR.
- R6: On a taken exception, every younger instruction is discarded on the same edge, whatever its own tag. The oldest faulting instruction therefore always wins, and writeback is empty in the following cycle.
- R7: `commit_o` is high exactly when writeback holds a valid, untagged instruction. A tagged instruction never commits.
- R8: `dmem_we_o` is high only when `mem_store_i` is high, the memory stage holds a valid untagged instruction, `dtlb_fault_i` is low, and no exception is being taken.
- R9: With `irq_i` high and no interrupt no-op in flight, the instruction fetched that cycle is replaced by a no-op with cause 1 and the fetch PC. This replacement takes precedence over a fetch translation fault on the same cycle.
- R10: At most one interrupt no-op is in flight. If an older exception discards it while `irq_i` stays high, a new one is injected after the redirect.
- R11: The saved exception PC and cause change only on the edge that follows `take_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_i | input | 1 | Level-sensitive external interrupt request |
| itlb_fault_i | input | 1 | Fetch translation fault for the instruction being fetched |
| illegal_i | input | 1 | Illegal encoding for the instruction in decode |
| ovf_i | input | 1 | Overflow for the instruction in execute |
| dtlb_fault_i | input | 1 | Data translation fault for the instruction in memory |
| mem_store_i | input | 1 | Instruction in memory wants to store |
| fetch_pc_o | output | PC_W | PC being fetched this cycle |
| wb_valid_o | output | 1 | Writeback stage holds an instruction |
| wb_pc_o | output | PC_W | PC of the writeback instruction |
| commit_o | output | 1 | Writeback instruction may update state |
| take_o | output | 1 | Exception taken this cycle |
| epc_o | output | PC_W | Saved exception PC |
| cause_o | output | 3 | Saved exception cause |
| dmem_we_o | output | 1 | Gated data-memory write enable |

## Verification
The checker assumes that all inputs are synchronous to `clk` and stable around the rising edge. It also assumes that fault flags for an empty stage may take any value without effect. The bench changes every input on the falling edge only. It drives fault flags freely, including while stages are empty after a flush, so the invalid-slot case is exercised. The bench's reference model decides which instruction each flag belongs to. This keeps the stimulus within those assumptions while covering overlapping faults in different stages.

// File: rtl/exc_pkg.sv
// Shared types for the precise exception tracker.
// Assumes a fixed five-stage order: fetch, decode, execute, memory, writeback.
package exc_pkg;

    // Cause codes; numeric values are visible on cause_o.
    typedef enum logic [2:0] {
        CZ_NONE = 3'd0,
        CZ_IRQ  = 3'd1,
        CZ_ITLB = 3'd2,
        CZ_ILL  = 3'd3,
        CZ_OVF  = 3'd4,
        CZ_DTLB = 3'd5
    } cause_e;

    // Per-slot tag carried down the pipeline.
    typedef struct packed {
        logic   vld;
        cause_e cz;
    } slot_t;

    // Stage registers after fetch: decode, execute, memory, writeback.
    localparam int NSLOT = 4;
    localparam int MEM_IDX = NSLOT - 2;
    localparam int WB_IDX  = NSLOT - 1;

endpackage

// File: rtl/exc_cause_merge.sv
// Attaches a stage's fault code to the instruction passing through it.
// Assumes an earlier-stage code is already present when non-zero; it is kept.
module exc_cause_merge
    import exc_pkg::*;
#(
    parameter cause_e CODE = CZ_ILL
) (
    input  slot_t in_s,
    input  logic  fault_i,
    output slot_t out_s
);

    // Keep the oldest cause, otherwise tag with this stage's code.
    always_comb begin
        out_s = in_s;
        if (in_s.vld && (in_s.cz == CZ_NONE) && fault_i)
            out_s.cz = CODE;
    end

endmodule

// File: rtl/exc_slot_reg.sv
// One pipeline stage register holding a tag and a PC.
// Assumes flush has priority over the incoming slot.
module exc_slot_reg
    import exc_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush_i,
    input  slot_t           d_s,
    input  logic [PC_W-1:0] d_pc,
    output slot_t           q_s,
    output logic [PC_W-1:0] q_pc
);

    // Capture the slot, emptying it on reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_s  <= '{vld: 1'b0, cz: CZ_NONE};
            q_pc <= '0;
        end else if (flush_i) begin
            q_s  <= '{vld: 1'b0, cz: CZ_NONE};
        end else begin
            q_s  <= d_s;
            q_pc <= d_pc;
        end
    end

endmodule

// File: rtl/exc_fetch_ctl.sv
// Fetch PC sequencing and interrupt no-op injection at fetch.
// Assumes one fetch per cycle and no stalls; redirect loads the vector.
module exc_fetch_ctl
    import exc_pkg::*;
#(
    parameter int              PC_W     = 32,
    parameter logic [PC_W-1:0] RESET_PC = '0,
    parameter logic [PC_W-1:0] VEC_ADDR = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            redirect_i,
    input  logic            irq_i,
    input  logic            irq_busy_i,
    input  logic            itlb_fault_i,
    output logic [PC_W-1:0] pc_o,
    output slot_t           slot_o
);

    localparam logic [PC_W-1:0] STEP = PC_W'(4);

    logic [PC_W-1:0] pc_q;

    // Advance the fetch PC or load the vector on redirect.
    always_ff @(posedge clk) begin
        if (!rst_n)          pc_q <= RESET_PC;
        else if (redirect_i) pc_q <= VEC_ADDR;
        else                 pc_q <= pc_q + STEP;
    end

    // Build the slot entering decode; interrupt wins over a fetch fault.
    always_comb begin
        slot_o.vld = 1'b1;
        if (irq_i && !irq_busy_i) slot_o.cz = CZ_IRQ;
        else if (itlb_fault_i)    slot_o.cz = CZ_ITLB;
        else                      slot_o.cz = CZ_NONE;
    end

    assign pc_o = pc_q;

endmodule

// File: rtl/exc_tracker.sv
// Precise exception tracker: tags instructions, acts at writeback only,
// saves PC and cause, redirects fetch and discards younger work.
// Assumes an in-order pipeline with no stalls; datapath lives elsewhere.
module exc_tracker
    import exc_pkg::*;
#(
    parameter int              PC_W     = 32,
    parameter logic [PC_W-1:0] RESET_PC = '0,
    parameter logic [PC_W-1:0] VEC_ADDR = PC_W'(32'h80)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            irq_i,
    input  logic            itlb_fault_i,
    input  logic            illegal_i,
    input  logic            ovf_i,
    input  logic            dtlb_fault_i,
    input  logic            mem_store_i,
    output logic [PC_W-1:0] fetch_pc_o,
    output logic            wb_valid_o,
    output logic [PC_W-1:0] wb_pc_o,
    output logic            commit_o,
    output logic            take_o,
    output logic [PC_W-1:0] epc_o,
    output logic [2:0]      cause_o,
    output logic            dmem_we_o
);

    slot_t           s_q  [NSLOT];
    logic [PC_W-1:0] pc_q [NSLOT];
    slot_t           d_s  [NSLOT];
    logic [PC_W-1:0] d_pc [NSLOT];
    logic [NSLOT-1:1] fv;
    slot_t           fetch_s;
    logic [PC_W-1:0] fetch_pc;
    logic            irq_busy;
    logic            take;
    logic [PC_W-1:0] epc_q;
    cause_e          cause_q;

    // Fault flags for the stage each slot is leaving.
    assign fv = {dtlb_fault_i, ovf_i, illegal_i};

    // Is an interrupt no-op already travelling down the pipe.
    always_comb begin
        irq_busy = 1'b0;
        for (int k = 0; k < NSLOT; k++)
            if (s_q[k].vld && (s_q[k].cz == CZ_IRQ)) irq_busy = 1'b1;
    end

    assign take = s_q[WB_IDX].vld && (s_q[WB_IDX].cz != CZ_NONE);

    exc_fetch_ctl #(
        .PC_W(PC_W), .RESET_PC(RESET_PC), .VEC_ADDR(VEC_ADDR)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n), .redirect_i(take), .irq_i(irq_i),
        .irq_busy_i(irq_busy), .itlb_fault_i(itlb_fault_i),
        .pc_o(fetch_pc), .slot_o(fetch_s)
    );

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        if (k == 0) begin : g_head
            assign d_s[k]  = fetch_s;
            assign d_pc[k] = fetch_pc;
        end else begin : g_body
            exc_cause_merge #(.CODE(cause_e'(3'(k + 2)))) u_merge (
                .in_s(s_q[k-1]), .fault_i(fv[k]), .out_s(d_s[k])
            );
            assign d_pc[k] = pc_q[k-1];
        end
        exc_slot_reg #(.PC_W(PC_W)) u_reg (
            .clk(clk), .rst_n(rst_n), .flush_i(take),
            .d_s(d_s[k]), .d_pc(d_pc[k]), .q_s(s_q[k]), .q_pc(pc_q[k])
        );
    end

    // Record the faulting PC and cause when the exception is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc_q   <= '0;
            cause_q <= CZ_NONE;
        end else if (take) begin
            epc_q   <= pc_q[WB_IDX];
            cause_q <= s_q[WB_IDX].cz;
        end
    end

    assign fetch_pc_o = fetch_pc;
    assign wb_valid_o = s_q[WB_IDX].vld;
    assign wb_pc_o    = pc_q[WB_IDX];
    assign commit_o   = s_q[WB_IDX].vld && (s_q[WB_IDX].cz == CZ_NONE);
    assign take_o     = take;
    assign epc_o      = epc_q;
    assign cause_o    = cause_q;
    assign dmem_we_o  = mem_store_i && s_q[MEM_IDX].vld &&
                        (s_q[MEM_IDX].cz == CZ_NONE) && !dtlb_fault_i && !take;

endmodule

// File: rtl/exc_tracker_chk.sv
// Temporal checks on the tracker's ports; attached by bind below.
// Assumes inputs are synchronous and reset is applied at start.
module exc_tracker_chk #(
    parameter int              PC_W     = 32,
    parameter logic [PC_W-1:0] VEC_ADDR = PC_W'(32'h80)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            take_o,
    input logic            wb_valid_o,
    input logic [PC_W-1:0] wb_pc_o,
    input logic [PC_W-1:0] fetch_pc_o,
    input logic [PC_W-1:0] epc_o,
    input logic [2:0]      cause_o,
    input logic            dmem_we_o
);

    // R5
    redirect_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> (fetch_pc_o == VEC_ADDR) && (epc_o == $past(wb_pc_o)));

    // R6
    flush_wb_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !wb_valid_o);

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |=> (fetch_pc_o == $past(fetch_pc_o) + PC_W'(4)));

    // R11
    epc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |=> ($stable(epc_o) && $stable(cause_o)));

    // R8
    store_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we_o |-> !take_o);

    // R3
    cause_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> (cause_o != 3'd0) && (cause_o <= 3'd5));

endmodule

bind exc_tracker exc_tracker_chk #(.PC_W(PC_W), .VEC_ADDR(VEC_ADDR)) u_chk (.*);

// File: tb/exc_tracker_test.sv
// Bench: behavioural reference model compared on every cycle.
module exc_tracker_test;

    localparam int          PC_W = 32;
    localparam logic [31:0] RPC  = 32'h100;
    localparam logic [31:0] VEC  = 32'h80;

    logic clk = 0, rst_n = 0;
    logic irq_i = 0, itlb_fault_i = 0, illegal_i = 0, ovf_i = 0;
    logic dtlb_fault_i = 0, mem_store_i = 0;
    logic [31:0] fetch_pc_o, wb_pc_o, epc_o;
    logic wb_valid_o, commit_o, take_o, dmem_we_o;
    logic [2:0] cause_o;

    int n_chk = 0, n_fail = 0, cyc = 0;

    // Reference state: stage 0 decode .. stage 3 writeback.
    bit          mv [4];
    logic [31:0] mp [4];
    int          mc [4];
    logic [31:0] mfpc, mepc;
    int          mcause;

    exc_tracker #(.PC_W(PC_W), .RESET_PC(RPC), .VEC_ADDR(VEC)) uut (.*);

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000) begin
            n_fail++;
            $display("FAIL watchdog got=%0d exp=<200000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin mv[i] = 0; mp[i] = 0; mc[i] = 0; end
        mfpc = RPC; mepc = 0; mcause = 0;
    endtask

    // One cycle: drive, compare, advance the model at the edge.
    task automatic step(input bit irq, input bit itlb, input bit ill,
                        input bit ovf, input bit dtlb, input bit st);
        bit tk, busy;
        int c;
        irq_i = irq; itlb_fault_i = itlb; illegal_i = ill;
        ovf_i = ovf; dtlb_fault_i = dtlb; mem_store_i = st;
        #1;
        tk = mv[3] && mc[3] != 0;
        chk("R2 fetch_pc", fetch_pc_o, mfpc);
        chk("R5 take", 32'(take_o), 32'(tk));
        chk("R7 commit", 32'(commit_o), 32'(mv[3] && mc[3] == 0));
        chk("R6 wb_valid", 32'(wb_valid_o), 32'(mv[3]));
        if (mv[3]) chk("R2 wb_pc", wb_pc_o, mp[3]);
        chk("R11 epc", epc_o, mepc);
        chk("R3 cause", 32'(cause_o), 32'(mcause));
        chk("R8 dmem_we", 32'(dmem_we_o),
            32'(st && mv[2] && mc[2] == 0 && !dtlb && !tk));
        @(posedge clk);
        if (tk) begin
            mepc = mp[3]; mcause = mc[3]; mfpc = VEC;
            for (int i = 0; i < 4; i++) mv[i] = 0;
        end else begin
            busy = 0;
            for (int i = 0; i < 4; i++) if (mv[i] && mc[i] == 1) busy = 1;
            for (int i = 3; i >= 1; i--) begin
                c = mc[i-1];
                if (mv[i-1] && c == 0) begin
                    if (i == 1 && ill)  c = 3;
                    if (i == 2 && ovf)  c = 4;
                    if (i == 3 && dtlb) c = 5;
                end
                mv[i] = mv[i-1]; mp[i] = mp[i-1]; mc[i] = c;
            end
            mv[0] = 1; mp[0] = mfpc;
            mc[0] = (irq && !busy) ? 1 : (itlb ? 2 : 0);
            mfpc = mfpc + 4;
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        logic [31:0] p;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk("R1 fetch_pc", fetch_pc_o, RPC);
        chk("R1 wb_valid", 32'(wb_valid_o), 0);
        chk("R1 epc", epc_o, 0);
        chk("R1 cause", 32'(cause_o), 0);

        // R2/R7: straight-line commit
        idle(8);
        // R8: stores with and without a memory fault
        step(0, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 1, 1);
        idle(6);

        // R4: illegal at decode then overflow at execute on one instruction
        p = fetch_pc_o - 4;
        step(0, 0, 1, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0);
        idle(2);
        chk("R4 epc", epc_o, p);
        chk("R4 cause", 32'(cause_o), 3);
        idle(6);

        // R6: older overflow wins over younger decode and fetch faults
        p = fetch_pc_o - 8;
        step(0, 1, 1, 1, 0, 1);
        idle(2);
        chk("R6 epc", epc_o, p);
        chk("R6 cause", 32'(cause_o), 4);
        chk("R6 wb_empty", 32'(wb_valid_o), 0);
        idle(6);

        // R9: interrupt no-op replaces fetched instruction, beats fetch fault
        p = fetch_pc_o;
        step(1, 1, 0, 0, 0, 0);
        for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, 0);
        chk("R9 epc", epc_o, p);
        chk("R9 cause", 32'(cause_o), 1);
        idle(6);

        // R10: interrupt no-op flushed by older fault, then reinjected
        p = fetch_pc_o - 8;
        step(1, 0, 0, 1, 0, 0);
        step(1, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0);
        chk("R10 first_epc", epc_o, p);
        chk("R10 first_cause", 32'(cause_o), 4);
        for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 0, 0);
        chk("R10 re_epc", epc_o, VEC);
        chk("R10 re_cause", 32'(cause_o), 1);
        idle(6);

        // R3: mixed random faults
        for (int i = 0; i < 400; i++)
            step($urandom_range(0, 15) == 0, $urandom_range(0, 19) == 0,
                 $urandom_range(0, 19) == 0, $urandom_range(0, 19) == 0,
                 $urandom_range(0, 19) == 0, $urandom_range(0, 2) == 0);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule